// File: doc/BRIEF.md
# Horizontal Microcoded Register Datapath

This block is an 8-bit datapath that executes one flat 22-bit control word on every rising clock edge. No instruction decoding and no sequencing take place inside it. Each word does three things. It picks a second ALU operand from one of four general registers or from a 256-byte memory. It picks one of eight ALU functions, whose first operand is always the accumulator-like register H. It writes either the ALU result or an 8-bit literal carried in the word into any mix of the five registers and the memory, all at once.

The 8-bit operand field has two roles. When write-back takes the literal, the field is that literal. The same field is also the memory address for both reads and writes. A memory write of a literal therefore always stores the address value itself. An external sequencer supplies the words, so the block has only a clock, a reset and the control word as inputs. Its outputs are the five register values, for observation.

Top module: `hmd_datapath`

## Requirements
- R1: A synchronous active-high reset clears registers A, B, C, D and H to zero on the next rising edge.
- R2: When control bit 8 is 0, the write-back value is the operand field, bits 7:0. Bits 13 (memory), 14 (A), 15 (B), 16 (C), 17 (D) and 18 (H) each enable one destination. Any combination of them loads in the same cycle.
- R3: A register whose enable bit is clear keeps its value across the edge.
- R4: Bits 21:19 select the second ALU operand. 000 is memory at the operand address, 001 is A, 010 is B, 011 is C and 100 is D. Codes 101, 110 and 111 give zero.
- R5: When bit 8 is 1, the write-back value is the ALU result, with H as the first operand X and the selected source as the second operand Y. Bits 11:9 choose the function: 000 X xor Y, 001 X or Y, 010 not Y, 011 X+Y+carry, 100 X, 101 Y, 110 minus X, 111 Y minus X.
- R6: Bit 12 is the carry-in and is added only by function 011. Every result is taken modulo 256, and the carry out is dropped.
- R7: With bit 13 set, the write-back value is stored at the memory address given by bits 7:0. All other locations are left unchanged.
- R8: All loads in a word use the values from before the edge. A word that reads and writes the same memory location sees the old contents, and a word that loads H computes with the old H.
- R9: A memory write with bit 8 at 0 stores the operand value at the address equal to that same operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cw | input | 22 | Horizontal control word applied this cycle |
| reg_a | output | 8 | Register A contents |
| reg_b | output | 8 | Register B contents |
| reg_c | output | 8 | Register C contents |
| reg_d | output | 8 | Register D contents |
| reg_h | output | 8 | Register H contents |

## Verification
Two activities can land in the same cycle. The first is a read of a memory location and a write to that same location. The second is register H serving as operand and destination at once. The bench sends one word that adds H to memory at an address and writes the sum back to that address and to A. It then reads the location into B; B must equal old H plus the old contents, and any second pass through the sum is caught. A separate word loads A and H with H+B, and both registers must hold the sum formed from the old H.

// File: rtl/hmd_pkg.sv
package hmd_pkg;
  localparam int CW_W      = 22;
  localparam int OP_LSB    = 0;
  localparam int WB_ALU    = 8;
  localparam int FN_LSB    = 9;
  localparam int CIN_BIT   = 12;
  localparam int LD_LSB    = 13;
  localparam int LD_W      = 6;
  localparam int SEL_LSB   = 19;
  localparam int NREG      = 5;

  typedef enum logic [2:0] {
    ALU_XOR   = 3'b000,
    ALU_OR    = 3'b001,
    ALU_NOTB  = 3'b010,
    ALU_ADD   = 3'b011,
    ALU_PASSA = 3'b100,
    ALU_PASSB = 3'b101,
    ALU_NEGA  = 3'b110,
    ALU_BSUBA = 3'b111
  } alu_fn_e;

  typedef enum logic [2:0] {
    SRC_MEM = 3'b000,
    SRC_A   = 3'b001,
    SRC_B   = 3'b010,
    SRC_C   = 3'b011,
    SRC_D   = 3'b100
  } src_sel_e;
endpackage

// File: rtl/hmd_alu.sv
module hmd_alu #(
  parameter int DW = 8
) (
  input  hmd_pkg::alu_fn_e fn,
  input  logic             cin,
  input  logic [DW-1:0]    x,
  input  logic [DW-1:0]    y,
  output logic [DW-1:0]    res
);
  import hmd_pkg::*;

  always_comb begin
    unique case (fn)
      ALU_XOR:   res = x ^ y;
      ALU_OR:    res = x | y;
      ALU_NOTB:  res = ~y;
      ALU_ADD:   res = x + y + DW'(cin);
      ALU_PASSA: res = x;
      ALU_PASSB: res = y;
      ALU_NEGA:  res = DW'(0) - x;
      ALU_BSUBA: res = y - x;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/hmd_mem.sv
module hmd_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/hmd_regfile.sv
module hmd_regfile #(
  parameter int DW = 8,
  parameter int N  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          ld,
  input  logic [DW-1:0]         wdata,
  output logic [N-1:0][DW-1:0]  q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (ld[i]) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/hmd_datapath.sv
module hmd_datapath #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [hmd_pkg::CW_W-1:0] cw,
  output logic [DW-1:0]          reg_a,
  output logic [DW-1:0]          reg_b,
  output logic [DW-1:0]          reg_c,
  output logic [DW-1:0]          reg_d,
  output logic [DW-1:0]          reg_h
);
  import hmd_pkg::*;

  localparam int AW = DW;
  localparam int IA = 0, IB = 1, IC = 2, ID = 3, IH = 4;

  logic [DW-1:0]           operand;
  logic                    wb_alu;
  alu_fn_e                 fn;
  logic                    cin;
  logic [LD_W-1:0]         ld;
  logic [2:0]              sel;
  logic [DW-1:0]           mem_rd;
  logic [DW-1:0]           src;
  logic [DW-1:0]           alu_res;
  logic [DW-1:0]           wdata;
  logic [NREG-1:0][DW-1:0] q;

  assign operand = cw[OP_LSB +: DW];
  assign wb_alu  = cw[WB_ALU];
  assign fn      = alu_fn_e'(cw[FN_LSB +: 3]);
  assign cin     = cw[CIN_BIT];
  assign ld      = cw[LD_LSB +: LD_W];
  assign sel     = cw[SEL_LSB +: 3];

  always_comb begin
    case (sel)
      SRC_MEM: src = mem_rd;
      SRC_A:   src = q[IA];
      SRC_B:   src = q[IB];
      SRC_C:   src = q[IC];
      SRC_D:   src = q[ID];
      default: src = '0;
    endcase
  end

  hmd_alu #(.DW(DW)) u_alu (
    .fn  (fn),
    .cin (cin),
    .x   (q[IH]),
    .y   (src),
    .res (alu_res)
  );

  assign wdata = wb_alu ? alu_res : operand;

  hmd_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (ld[0] & ~rst),
    .addr  (operand),
    .wdata (wdata),
    .rdata (mem_rd)
  );

  hmd_regfile #(.DW(DW), .N(NREG)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .ld    (ld[LD_W-1:1]),
    .wdata (wdata),
    .q     (q)
  );

  assign reg_a = q[IA];
  assign reg_b = q[IB];
  assign reg_c = q[IC];
  assign reg_d = q[ID];
  assign reg_h = q[IH];
endmodule

// File: rtl/hmd_datapath_chk.sv
module hmd_datapath_chk #(
  parameter int DW = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [hmd_pkg::CW_W-1:0] cw,
  input logic [DW-1:0]            reg_a,
  input logic [DW-1:0]            reg_b,
  input logic [DW-1:0]            reg_c,
  input logic [DW-1:0]            reg_d,
  input logic [DW-1:0]            reg_h
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (reg_a == '0 && reg_b == '0 && reg_c == '0 && reg_d == '0 && reg_h == '0));

  p_imm_load_a_r2: assert property (@(posedge clk) disable iff (rst)
    (cw[14] && !cw[8]) |=> reg_a == $past(cw[7:0]));

  p_hold_b_r3: assert property (@(posedge clk) disable iff (rst)
    !cw[15] |=> $stable(reg_b));

  p_hold_d_r3: assert property (@(posedge clk) disable iff (rst)
    !cw[17] |=> $stable(reg_d));

  p_unused_sel_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cw[14] && cw[8] && cw[11:9] == 3'b101 && cw[21:19] >= 3'b101) |=> reg_a == '0);

  p_add_into_h_r6: assert property (@(posedge clk) disable iff (rst)
    (cw[18] && cw[8] && cw[11:9] == 3'b011 && cw[21:19] == 3'b001)
      |=> reg_h == DW'($past(reg_h) + $past(reg_a) + DW'($past(cw[12]))));
endmodule

bind hmd_datapath hmd_datapath_chk #(.DW(DW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cw    (cw),
  .reg_a (reg_a),
  .reg_b (reg_b),
  .reg_c (reg_c),
  .reg_d (reg_d),
  .reg_h (reg_h)
);

// File: tb/hmd_datapath_tb.sv
module hmd_datapath_tb;
  localparam int DW = 8;
  localparam logic [5:0] M_MEM = 6'b000001, M_A = 6'b000010, M_B = 6'b000100,
                         M_C = 6'b001000, M_D = 6'b010000, M_H = 6'b100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [21:0] cw = '0;
  logic [DW-1:0] reg_a, reg_b, reg_c, reg_d, reg_h;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  hmd_datapath #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cw(cw),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .reg_h(reg_h)
  );

  function automatic logic [21:0] mk(input logic [2:0] sel, input logic [5:0] mask,
                                     input logic cin, input logic [2:0] fn,
                                     input logic alu, input logic [7:0] op);
    return {sel, mask, cin, fn, alu, op};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic step(input logic [21:0] w);
    @(negedge clk) cw = w;
    @(negedge clk) cw = '0;
  endtask

  task automatic set_imm(input logic [5:0] mask, input logic [7:0] v);
    step(mk(3'b000, mask, 1'b0, 3'b000, 1'b0, v));
  endtask

  task automatic mem_wr_h(input logic [7:0] addr);
    step(mk(3'b000, M_MEM, 1'b0, 3'b100, 1'b1, addr));
  endtask

  task automatic mem_rd_b(input logic [7:0] addr);
    step(mk(3'b000, M_B, 1'b0, 3'b101, 1'b1, addr));
  endtask

  task automatic t_reset;
    check("R1 A", reg_a, 8'h00); check("R1 B", reg_b, 8'h00);
    check("R1 C", reg_c, 8'h00); check("R1 D", reg_d, 8'h00);
    check("R1 H", reg_h, 8'h00);
  endtask

  task automatic t_imm;
    set_imm(M_A | M_C, 8'h12);
    check("R2 A", reg_a, 8'h12); check("R2 C", reg_c, 8'h12);
    check("R3 B", reg_b, 8'h00); check("R3 D", reg_d, 8'h00);
    check("R3 H", reg_h, 8'h00);
  endtask

  task automatic t_alu;
    logic [7:0] exp [8];
    set_imm(M_H, 8'h5A);
    set_imm(M_B, 8'h3C);
    exp = '{8'h66, 8'h7E, 8'hC3, 8'h96, 8'h5A, 8'h3C, 8'hA6, 8'hE2};
    for (int f = 0; f < 8; f++) begin
      step(mk(3'b010, M_A, 1'b0, 3'(f), 1'b1, 8'h00));
      check($sformatf("R5 fn%0d", f), reg_a, exp[f]);
    end
    check("R3 H kept", reg_h, 8'h5A);
  endtask

  task automatic t_carry;
    set_imm(M_H, 8'hFF);
    set_imm(M_B, 8'h01);
    step(mk(3'b010, M_A, 1'b1, 3'b011, 1'b1, 8'h00));
    check("R6 wrap", reg_a, 8'h01);
    step(mk(3'b010, M_A, 1'b1, 3'b100, 1'b1, 8'h00));
    check("R6 cin ignored", reg_a, 8'hFF);
    set_imm(M_H, 8'h10);
    step(mk(3'b010, M_A, 1'b1, 3'b011, 1'b1, 8'h00));
    check("R6 cin add", reg_a, 8'h12);
  endtask

  task automatic t_sel;
    set_imm(M_C, 8'h77);
    set_imm(M_D, 8'h88);
    step(mk(3'b011, M_A, 1'b0, 3'b101, 1'b1, 8'h00));
    check("R4 sel C", reg_a, 8'h77);
    step(mk(3'b100, M_A, 1'b0, 3'b101, 1'b1, 8'h00));
    check("R4 sel D", reg_a, 8'h88);
    for (int s = 5; s < 8; s++) begin
      set_imm(M_A, 8'hEE);
      step(mk(3'(s), M_A, 1'b0, 3'b101, 1'b1, 8'h00));
      check($sformatf("R4 sel %0d zero", s), reg_a, 8'h00);
    end
  endtask

  task automatic t_mem;
    set_imm(M_H, 8'h21); mem_wr_h(8'h05);
    set_imm(M_H, 8'h33); mem_wr_h(8'h06);
    mem_rd_b(8'h05); check("R7 read 5", reg_b, 8'h21);
    mem_rd_b(8'h06); check("R7 neighbour 6", reg_b, 8'h33);
    step(mk(3'b000, M_MEM, 1'b0, 3'b000, 1'b0, 8'h40));
    mem_rd_b(8'h40); check("R9 const to mem", reg_b, 8'h40);
    mem_rd_b(8'h05); check("R9 other addr", reg_b, 8'h21);
  endtask

  task automatic t_same;
    set_imm(M_H, 8'h10);
    step(mk(3'b000, M_MEM | M_A, 1'b0, 3'b011, 1'b1, 8'h05));
    check("R8 A gets old mem", reg_a, 8'h31);
    mem_rd_b(8'h05); check("R8 mem once", reg_b, 8'h31);
    set_imm(M_B, 8'h02);
    step(mk(3'b010, M_A | M_H, 1'b0, 3'b011, 1'b1, 8'h00));
    check("R8 A old H", reg_a, 8'h12);
    check("R8 H old H", reg_h, 8'h12);
  endtask

  initial begin
    #40000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_imm;
    t_alu;
    t_carry;
    t_sel;
    t_mem;
    t_same;
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 re-reset A", reg_a, 8'h00);
    check("R1 re-reset H", reg_h, 8'h00);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule